// File: doc/BRIEF.md
# Prescaled System Timer with Four Compare Channels

This block is a free-running 32-bit up-counter for use as a shared timestamp and event source. A programmable prescaler derives a count tick from the module clock. Software reaches everything through a plain 32-bit register port: it can start and stop the counter, load any count value, pick the division ratio, and choose whether counting pauses while the debug-halt input is high. The counter wraps silently at the top of its range, and there is no overflow flag of its own.

Four compare channels each hold a 32-bit match value, an enable bit and a sticky flag. A flag sets on the tick that brings the counter onto the channel's match value. Each channel drives its own interrupt line, which is high while the flag is set and the channel is enabled. Software detects a wrap by loading 0 as the match value of one channel.

Tick generation is a three-state machine. The states are `ST_STOP` (run bit clear), `ST_RUN` (counting) and `ST_HOLD` (run bit set while frozen by debug). The machine moves between them on these events:
- STOP→RUN when the run bit is set.
- RUN→HOLD and STOP→HOLD when the freeze bit and debug-halt are both high.
- HOLD→RUN when either of them drops.
- Any state→STOP when the run bit is cleared.

The state register follows the control bits with one cycle of delay.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads as zero and all four interrupt lines are low.
- R2: On each tick the counter increases by exactly one. After 0xFFFFFFFF it wraps to 0.
- R3: The prescale field sits in control register (0x00) bits 15:8. A field value N gives one tick every N+1 clocks. Counting starts from a loaded value with a cleared prescaler phase, and the run bit is written at clock edge E0. After n more edges the count has advanced by floor((n-1)/(N+1)).
- R4: Control bit 0 is the run bit. When it is clear, the count holds its value.
- R5: Control bit 1 is the freeze bit. While it is set and debug_halt is high, the count holds. Counting resumes one edge after debug_halt falls. With the freeze bit clear, debug_halt has no effect.
- R6: Address 0x04 reads the live count. A write to it loads the written value on that edge, overriding any tick, and resets the prescaler phase.
- R7: Channel k (0..3) occupies base 0x10+0x10*k: bit 0 at base+0 is the enable, bit 0 at base+4 is the flag, and base+8 holds the 32-bit match value. The unimplemented bits of the control registers read as zero.
- R8: A channel's flag sets on a tick that makes the counter equal to the channel's match value while the channel is enabled. Loading the counter with that value does not set the flag.
- R9: A flag stays set until software writes 1 to bit 0 of the flag register. Writing 0 there leaves the flag unchanged.
- R10: irq[k] is high exactly when channel k's flag and enable are both set. Clearing the enable masks the line but keeps the flag.
- R11: A channel with match value 0 that is enabled sets its flag when the counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| debug_halt | input | 1 | Debug halt request, freezes counting when enabled |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The prescaler is driven with division values 0, 1, 3 and 255. At each value the count is sampled at elapsed-cycle counts just below and just on a tick boundary, which separates a divide-by-N error from a divide-by-N+1 error and exposes an off-by-one start latency. Compare matching is tried in three ways: a mid-range match reached by counting, a match value reached only by a software load, and a zero match reached by wrapping. Together these separate tick-driven flag setting from value equality alone. The flag is written with 0, then masked, then written with 1, which separates sticky flag behaviour from interrupt masking. Freezing is tried with and without the freeze bit under the same debug-halt level.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_COUNT = 4'h4;
    localparam logic [3:0] OFS_CH_EN   = 4'h0;
    localparam logic [3:0] OFS_CH_FLAG = 4'h4;
    localparam logic [3:0] OFS_CH_CMP  = 4'h8;
    localparam int         CTRL_RUN_BIT = 0;
    localparam int         CTRL_FRZ_BIT = 1;
    localparam int         CTRL_PSC_LSB = 8;
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc
    import cmp_timer_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             frz,
    input  logic             debug_halt,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic             tick
);
    tmr_state_e       state_q, state_d;
    logic [PSC_W-1:0] div_q;

    always_comb begin
        if (!run)
            state_d = ST_STOP;
        else if (frz && debug_halt)
            state_d = ST_HOLD;
        else
            state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            ST_STOP: tick = 1'b0;
            ST_RUN:  tick = (div_q == psc) && !restart;
            ST_HOLD: tick = 1'b0;
            default: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart || state_q == ST_STOP)
            div_q <= '0;
        else if (state_q == ST_RUN)
            div_q <= (div_q == psc) ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_reg,
    input  logic             wr_flag_reg,
    input  logic             wr_cmp_reg,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             en_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);
    logic hit;

    assign hit = tick && en_o && (cnt_next == cmp_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            cmp_o <= '0;
        end else begin
            if (wr_en_reg)  en_o  <= wdata[0];
            if (wr_cmp_reg) cmp_o <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (hit)
            flag_o <= 1'b1;
        else if (wr_flag_reg && wdata[0])
            flag_o <= 1'b0;
    end

    assign irq_o = flag_o & en_o;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 8,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              debug_halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [N_CH-1:0]   irq
);
    localparam int GRP_W = ADDR_W - 4;

    logic             run_q, frz_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             tick, cnt_wr, ctrl_wr;
    logic [GRP_W-1:0] grp;
    logic [3:0]       sub;

    logic [N_CH-1:0]  en_q, flag_q;
    logic [CNT_W-1:0] cmp_q [N_CH];

    assign grp     = addr[ADDR_W-1:4];
    assign sub     = addr[3:0];
    assign ctrl_wr = wr_en && grp == '0 && sub == OFS_CTRL;
    assign cnt_wr  = wr_en && grp == '0 && sub == OFS_COUNT;
    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            frz_q <= 1'b0;
            psc_q <= '0;
        end else if (ctrl_wr) begin
            run_q <= wdata[CTRL_RUN_BIT];
            frz_q <= wdata[CTRL_FRZ_BIT];
            psc_q <= wdata[CTRL_PSC_LSB +: PSC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wdata;
        else if (tick)
            cnt_q <= cnt_nxt;
    end

    cmp_timer_presc #(.PSC_W(PSC_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .frz        (frz_q),
        .debug_halt (debug_halt),
        .psc        (psc_q),
        .restart    (cnt_wr),
        .tick       (tick)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic grp_hit;
        assign grp_hit = wr_en && grp == GRP_W'(k + 1);

        cmp_timer_chan #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en_reg   (grp_hit && sub == OFS_CH_EN),
            .wr_flag_reg (grp_hit && sub == OFS_CH_FLAG),
            .wr_cmp_reg  (grp_hit && sub == OFS_CH_CMP),
            .wdata       (wdata),
            .tick        (tick),
            .cnt_next    (cnt_nxt),
            .en_o        (en_q[k]),
            .flag_o      (flag_q[k]),
            .cmp_o       (cmp_q[k]),
            .irq_o       (irq[k])
        );
    end

    always_comb begin
        rdata = '0;
        if (grp == '0) begin
            if (sub == OFS_CTRL) begin
                rdata[CTRL_RUN_BIT]             = run_q;
                rdata[CTRL_FRZ_BIT]             = frz_q;
                rdata[CTRL_PSC_LSB +: PSC_W]    = psc_q;
            end else if (sub == OFS_COUNT) begin
                rdata = cnt_q;
            end
        end
        for (int k = 0; k < N_CH; k++) begin
            if (grp == GRP_W'(k + 1)) begin
                if (sub == OFS_CH_EN)        rdata[0] = en_q[k];
                else if (sub == OFS_CH_FLAG) rdata[0] = flag_q[k];
                else if (sub == OFS_CH_CMP)  rdata = cmp_q[k];
            end
        end
    end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              debug_halt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              run_q,
    input logic              frz_q,
    input logic              tick,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [N_CH-1:0]   en_q,
    input logic [N_CH-1:0]   flag_q,
    input logic [N_CH-1:0]   irq
);
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    p_stopped_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && $past(!run_q)) |-> !tick);

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && debug_halt && $past(frz_q && debug_halt)) |-> !tick);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wdata));

    for (genvar k = 0; k < N_CH; k++) begin : g_chk
        localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(16 * (k + 1) + 4);

        p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[k]) |-> $past(tick && en_q[k]));

        p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[k]) |-> $past(wr_en && addr == FLAG_ADDR && wdata[0]));

        p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[k] |-> !irq[k]);
    end
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .debug_halt (debug_halt),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .run_q      (run_q),
    .frz_q      (frz_q),
    .tick       (tick),
    .cnt_wr     (cnt_wr),
    .cnt_q      (cnt_q),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .irq        (irq)
);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        debug_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .debug_halt(debug_halt), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // prescale field, edges after run write, expected count (R3)
    localparam int NV = 9;
    localparam int VEC [NV][3] = '{
        '{0, 1, 0}, '{0, 10, 9}, '{1, 10, 4}, '{3, 16, 3}, '{3, 17, 4},
        '{255, 256, 0}, '{255, 257, 1}, '{255, 300, 1}, '{2, 7, 2}
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h04, v); check("R1 count", v, 0);
        rd(8'h28, v); check("R1 ch1 cmp", v, 0);
        check("R1 irq", {28'd0, irq}, 0);

        // R3 table walk
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 32'h0);
            wr(8'h04, 32'h0);
            wr(8'h00, (VEC[i][0] << 8) | 32'h1);
            edges(VEC[i][1]);
            rd(8'h04, v);
            check("R3 prescale count", v, VEC[i][2]);
        end

        // R7 control readback, unimplemented bits zero
        wr(8'h00, 32'hFFFF_AB00);
        rd(8'h00, v); check("R7 ctrl readback", v, 32'h0000_AB00);

        // R4 stop holds count
        wr(8'h00, 32'h1);
        edges(5);
        wr(8'h00, 32'h0);
        edges(1);
        rd(8'h04, v);
        edges(6);
        rd(8'h04, v2); check("R4 stopped hold", v2, v);

        // R6 load while running, then counting continues
        wr(8'h00, 32'h1);
        edges(2);
        wr(8'h04, 32'd100);
        rd(8'h04, v); check("R6 load", v, 100);
        edges(3);
        rd(8'h04, v); check("R6 after load", v, 103);

        // R5 freeze with debug halt
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        debug_halt = 1'b1;
        wr(8'h00, 32'h3);
        edges(5);
        rd(8'h04, v); check("R5 frozen", v, 0);
        debug_halt = 1'b0;
        edges(5);
        rd(8'h04, v); check("R5 resume", v, 4);
        // R5 debug ignored without freeze bit
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        debug_halt = 1'b1;
        wr(8'h00, 32'h1);
        edges(10);
        rd(8'h04, v); check("R5 no freeze bit", v, 9);
        debug_halt = 1'b0;

        // R8 match by counting on channel 1
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h28, 32'd5);
        wr(8'h20, 32'h1);
        wr(8'h00, 32'h1);
        edges(4);
        rd(8'h24, v); check("R8 no flag before match", v, 0);
        edges(6);
        rd(8'h24, v); check("R8 flag on match", v, 1);
        check("R10 irq line", {28'd0, irq}, 32'h2);

        // R9 write 0 no effect, R10 mask, R9 write 1 clears
        wr(8'h24, 32'h0);
        rd(8'h24, v); check("R9 write0 keeps flag", v, 1);
        wr(8'h20, 32'h0);
        check("R10 masked irq", {28'd0, irq}, 0);
        rd(8'h24, v); check("R10 flag kept when masked", v, 1);
        wr(8'h24, 32'h1);
        rd(8'h24, v); check("R9 write1 clears", v, 0);

        // R8 load onto match value sets nothing
        wr(8'h00, 32'h0);
        wr(8'h48, 32'h200);
        wr(8'h40, 32'h1);
        wr(8'h04, 32'h200);
        edges(2);
        rd(8'h44, v); check("R8 load no flag", v, 0);
        check("R8 load no irq", {28'd0, irq}, 0);
        wr(8'h40, 32'h0);

        // R11 / R2 wrap detection on channel 0
        wr(8'h18, 32'h0);
        wr(8'h10, 32'h1);
        wr(8'h04, 32'hFFFF_FFFD);
        wr(8'h00, 32'h1);
        edges(3);
        rd(8'h14, v); check("R11 no flag before wrap", v, 0);
        edges(2);
        rd(8'h04, v); check("R2 wrap count", v, 1);
        rd(8'h14, v); check("R11 wrap flag", v, 1);
        check("R11 wrap irq", {28'd0, irq}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule